// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a synchronous host and one external asynchronous static RAM of 262,144 sixteen-bit words. The host raises a request with an address, a read/write flag, write data and a two-bit byte mask, and holds it until a single-cycle acknowledge comes back. The controller then produces the memory strobes: an 18-bit address, a low-active and a high-active chip select, write and output strobes, and one low-active enable per byte lane. All of these come straight from registers. The bidirectional data bus appears as three separate signals: drive value, drive enable and sampled input.

Strobe widths are counted in clock cycles. Each count is rounded up from a nanosecond limit given as a parameter, using the clock period, which is also a parameter. The output strobe stays inactive for the whole of a write. A write whose last bus operation was a read waits a fixed number of quiet cycles first, so that the memory's drivers have floated before the controller drives the bus. A request with an empty byte mask is acknowledged without any bus activity. Between operations the address and data registers hold their last values, so that the memory can fall to its lowest standby current.

Top module: `sram16_ctrl`

## Requirements
- R1: After reset and whenever no operation is in progress, the chip is deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_ub_n`=`mem_lb_n`=1 and `mem_dq_oe`=0. `mem_addr` keeps its last value (0 after reset).
- R2: An accepted read with a non-zero mask makes the controller drive the request address with `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1. These values hold for RD_CYC = ceil(T_RD_NS/CLK_NS) consecutive cycles, starting the cycle after the accepting edge (5 at the defaults). `mem_dq_oe` stays 0.
- R3: `mem_dq_in` is registered at the edge that ends the last read cycle. In the next cycle `host_ack` is 1 for one cycle, `host_rdata` carries the registered value and `host_ack_addr` carries the request address. `host_rdata` changes only in a cycle where `host_ack` is 1.
- R4: `host_bmask` bit 0 selects data bits 7:0 through `mem_lb_n`=0. Bit 1 selects bits 15:8 through `mem_ub_n`=0. During any operation at least one of the two is low. On a read, the bits of a lane that was not selected are returned as zero.
- R5: An accepted write holds `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_out`=write data, together with the address, chip selects and lane enables. This lasts WLOW_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-1) cycles (4 at the defaults). One hold cycle follows with `mem_we_n`=1 and data still driven. The acknowledge comes in the cycle after that.
- R6: When the previous bus operation was a read, a write first spends TURN_CYC = ceil(T_TURN_NS/CLK_NS) cycles (2 at the defaults) with every strobe idle and `mem_dq_oe`=0. Only after these cycles does it assert its strobes.
- R7: A request whose mask is 0 is acknowledged in the cycle after acceptance. No memory pin changes, and `host_rdata` keeps its value.
- R8: `host_ack` is never high for two cycles in a row. The host drops `host_req` in the acknowledge cycle. Each handshake causes exactly one operation.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_bmask | input | 2 | Byte lanes to access (bit 0 = bits 7:0) |
| host_ack | output | 1 | One-cycle completion pulse |
| host_ack_addr | output | 18 | Address of the completed request |
| host_rdata | output | 16 | Read data, valid with the acknowledge |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Value sampled from the data bus |

## Verification
The assertions assume that the host holds its request fields stable from the raise of `host_req` until the acknowledge, and drops the request in the acknowledge cycle. The bench only raises a request after the previous acknowledge cycle and one quiet cycle have passed, and it changes fields only while the request is low. The bench's memory model drives junk on lanes that are not selected and returns data only while both chip selects and the output strobe are active. The stimulus mixes fixed corner cases with random sequences over a small set of addresses, so that rewrites, turnaround after a read and empty masks all occur.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WPULSE,
        ST_WHOLD
    } sram_state_e;

    // Round a nanosecond limit up to whole clocks, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sram16_cycle_timer.sv
module sram16_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // After a load of N, done is high in the Nth following cycle.
    always_comb begin
        if (load)
            cnt_d = load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram16_lane_gate.sv
module sram16_lane_gate #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] din,
    output logic [LANES*8-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram16_ctrl.sv
module sram16_ctrl
    import sram16_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 8,
    parameter int T_RD_NS   = 35,
    parameter int T_WP_NS   = 25,
    parameter int T_DS_NS   = 15,
    parameter int T_WC_NS   = 35,
    parameter int T_TURN_NS = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_write,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [DATA_W/8-1:0] host_bmask,
    output logic                host_ack,
    output logic [ADDR_W-1:0]   host_ack_addr,
    output logic [DATA_W-1:0]   host_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce1_n,
    output logic                mem_ce2,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    localparam int LANES    = DATA_W / 8;
    localparam int RD_CYC   = ns_to_cycles(T_RD_NS, CLK_NS);
    localparam int TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_NS);
    localparam int WLOW_CYC = max3(ns_to_cycles(T_WP_NS, CLK_NS),
                                   ns_to_cycles(T_DS_NS, CLK_NS),
                                   ns_to_cycles(T_WC_NS, CLK_NS) - 1);
    localparam int MAX_CYC  = max3(RD_CYC, TURN_CYC, WLOW_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        sram_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dout;
        logic              dq_oe;
        logic              sel;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic              ack;
        logic [ADDR_W-1:0] ack_addr;
        logic [DATA_W-1:0] rdata;
        logic              after_rd;
        logic [ADDR_W-1:0] p_addr;
        logic [DATA_W-1:0] p_data;
        logic [LANES-1:0]  p_mask;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic [DATA_W-1:0] rd_gated;

    logic              go_write;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic [LANES-1:0]  w_mask;

    sram16_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram16_lane_gate #(.LANES(LANES)) u_gate (
        .lane_en (~r_q.be_n),
        .din     (mem_dq_in),
        .dout    (rd_gated)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go_write = 1'b0;
        w_addr   = r_q.p_addr;
        w_data   = r_q.p_data;
        w_mask   = r_q.p_mask;

        case (r_q.state)
            ST_IDLE: begin
                if (host_req && !r_q.ack) begin
                    if (host_bmask == '0) begin
                        r_d.ack      = 1'b1;
                        r_d.ack_addr = host_addr;
                    end else if (!host_write) begin
                        r_d.state    = ST_READ;
                        r_d.addr     = host_addr;
                        r_d.sel      = 1'b1;
                        r_d.oe_n     = 1'b0;
                        r_d.be_n     = ~host_bmask;
                        r_d.after_rd = 1'b1;
                        tmr_load     = 1'b1;
                        tmr_val      = CNT_W'(RD_CYC);
                    end else if (r_q.after_rd) begin
                        r_d.state  = ST_TURN;
                        r_d.p_addr = host_addr;
                        r_d.p_data = host_wdata;
                        r_d.p_mask = host_bmask;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(TURN_CYC);
                    end else begin
                        go_write = 1'b1;
                        w_addr   = host_addr;
                        w_data   = host_wdata;
                        w_mask   = host_bmask;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_done) go_write = 1'b1;
            end
            ST_READ: begin
                if (tmr_done) begin
                    r_d.state    = ST_IDLE;
                    r_d.rdata    = rd_gated;
                    r_d.ack      = 1'b1;
                    r_d.ack_addr = r_q.addr;
                    r_d.sel      = 1'b0;
                    r_d.oe_n     = 1'b1;
                    r_d.be_n     = '1;
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    r_d.state = ST_WHOLD;
                    r_d.we_n  = 1'b1;
                end
            end
            ST_WHOLD: begin
                r_d.state    = ST_IDLE;
                r_d.dq_oe    = 1'b0;
                r_d.sel      = 1'b0;
                r_d.be_n     = '1;
                r_d.ack      = 1'b1;
                r_d.ack_addr = r_q.addr;
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (go_write) begin
            r_d.state    = ST_WPULSE;
            r_d.addr     = w_addr;
            r_d.dout     = w_data;
            r_d.dq_oe    = 1'b1;
            r_d.sel      = 1'b1;
            r_d.we_n     = 1'b0;
            r_d.oe_n     = 1'b1;
            r_d.be_n     = ~w_mask;
            r_d.after_rd = 1'b0;
            tmr_load     = 1'b1;
            tmr_val      = CNT_W'(WLOW_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.we_n     <= 1'b1;
            r_q.oe_n     <= 1'b1;
            r_q.be_n     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ack      = r_q.ack;
    assign host_ack_addr = r_q.ack_addr;
    assign host_rdata    = r_q.rdata;
    assign mem_addr      = r_q.addr;
    assign mem_ce1_n     = ~r_q.sel;
    assign mem_ce2       = r_q.sel;
    assign mem_we_n      = r_q.we_n;
    assign mem_oe_n      = r_q.oe_n;
    assign mem_lb_n      = r_q.be_n[0];
    assign mem_ub_n      = r_q.be_n[LANES-1];
    assign mem_dq_out    = r_q.dout;
    assign mem_dq_oe     = r_q.dq_oe;
endmodule

// File: rtl/sram16_ctrl_chk.sv
module sram16_ctrl_chk
    import sram16_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 8,
    parameter int T_TURN_NS = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ack,
    input logic [DATA_W-1:0] host_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);
    localparam int TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_NS);

    // Cycles since the output strobe was last active (saturating).
    logic [7:0] quiet_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 quiet_cnt <= 8'hFF;
        else if (!mem_oe_n)      quiet_cnt <= 8'h00;
        else if (quiet_cnt != 8'hFF) quiet_cnt <= quiet_cnt + 8'h01;
    end

    assert_idle_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_ce1_n && $past(mem_ce1_n)) |-> $stable(mem_addr));

    assert_strobe_selects_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> (!mem_ce1_n && mem_ce2));

    assert_rdata_only_on_ack_R3: assert property (@(posedge clk) disable iff (rst)
        !host_ack |-> $stable(host_rdata));

    assert_lane_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !(mem_ub_n && mem_lb_n));

    assert_write_drives_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (quiet_cnt > 8'(TURN_CYC)));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
endmodule

bind sram16_ctrl sram16_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CLK_NS    (CLK_NS),
    .T_TURN_NS (T_TURN_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .mem_addr   (mem_addr),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram16_ctrl_test.sv
module sram16_ctrl_test;
    localparam int RD = 5;   // ceil(35/8)
    localparam int WL = 4;   // max(ceil(25/8), ceil(15/8), ceil(35/8)-1)
    localparam int TN = 2;   // ceil(15/8)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_bmask = '0;
    logic        host_ack;
    logic [17:0] host_ack_addr;
    logic [15:0] host_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #4 clk = ~clk;

    sram16_ctrl uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_ack(host_ack), .host_ack_addr(host_ack_addr), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // ---------------- memory device model ----------------
    logic [15:0] dev_mem [int];
    logic [15:0] ref_mem [int];

    function automatic logic [15:0] init_word(input logic [17:0] a);
        return a[15:0] ^ {a[17:16], a[13:0]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] dev_word(input logic [17:0] a);
        if (dev_mem.exists(int'(a))) return dev_mem[int'(a)];
        return init_word(a);
    endfunction

    always @(*) begin
        logic [15:0] w;
        w = dev_word(mem_addr);
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
            mem_dq_in = {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
        else
            mem_dq_in = 16'hEEEE;
    end

    always @(posedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = dev_word(mem_addr);
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            dev_mem[int'(mem_addr)] = w;
        end
    end

    // ---------------- reference model ----------------
    typedef struct {
        logic [17:0] addr;
        bit          sel, we_n, oe_n, dq_oe, ack;
        logic [1:0]  be_n;
        logic [15:0] dout;
        logic [17:0] aaddr;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    bit          last_rd = 1'b0;
    logic [17:0] cur_addr = '0;
    logic [15:0] last_rdata = '0;

    function automatic exp_t mk_idle(input string tag);
        exp_t e;
        e.addr = cur_addr; e.sel = 0; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0;
        e.ack = 0; e.be_n = 2'b11; e.dout = '0; e.aaddr = '0;
        e.rdata = last_rdata; e.tag = tag;
        return e;
    endfunction

    task automatic fail_line(input string tag, input string what,
                             input logic [31:0] got, input logic [31:0] exp);
        $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
    endtask

    task automatic step(input exp_t e);
        bit bad;
        @(negedge clk);
        bad = 0;
        n_checks++;
        if (mem_addr !== e.addr)   begin bad = 1; fail_line(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr)); end
        if (mem_ce1_n !== !e.sel)  begin bad = 1; fail_line(e.tag, "mem_ce1_n", 32'(mem_ce1_n), 32'(!e.sel)); end
        if (mem_ce2 !== e.sel)     begin bad = 1; fail_line(e.tag, "mem_ce2", 32'(mem_ce2), 32'(e.sel)); end
        if (mem_we_n !== e.we_n)   begin bad = 1; fail_line(e.tag, "mem_we_n", 32'(mem_we_n), 32'(e.we_n)); end
        if (mem_oe_n !== e.oe_n)   begin bad = 1; fail_line(e.tag, "mem_oe_n", 32'(mem_oe_n), 32'(e.oe_n)); end
        if ({mem_ub_n, mem_lb_n} !== e.be_n)
            begin bad = 1; fail_line(e.tag, "byte enables", 32'({mem_ub_n, mem_lb_n}), 32'(e.be_n)); end
        if (mem_dq_oe !== e.dq_oe) begin bad = 1; fail_line(e.tag, "mem_dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe)); end
        if (e.dq_oe && mem_dq_out !== e.dout)
            begin bad = 1; fail_line(e.tag, "mem_dq_out", 32'(mem_dq_out), 32'(e.dout)); end
        if (host_ack !== e.ack)    begin bad = 1; fail_line(e.tag, "host_ack", 32'(host_ack), 32'(e.ack)); end
        if (host_rdata !== e.rdata)
            begin bad = 1; fail_line(e.tag, "host_rdata", 32'(host_rdata), 32'(e.rdata)); end
        if (e.ack && host_ack_addr !== e.aaddr)
            begin bad = 1; fail_line(e.tag, "host_ack_addr", 32'(host_ack_addr), 32'(e.aaddr)); end
        if (bad) n_fail++;
    endtask

    // Issue one request (called just after a falling edge) and check every cycle.
    task automatic op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m);
        exp_t q[$];
        exp_t e;
        host_req = 1; host_write = wr; host_addr = a; host_wdata = d; host_bmask = m;
        if (m == 2'b00) begin
            e = mk_idle("R7 empty mask");
            e.ack = 1; e.aaddr = a;
            q.push_back(e);
        end else if (!wr) begin
            logic [15:0] w;
            w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
            cur_addr = a;
            for (int i = 0; i < RD; i++) begin
                e = mk_idle("R2 read strobe");
                e.sel = 1; e.oe_n = 0; e.be_n = ~m;
                q.push_back(e);
            end
            last_rdata = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
            e = mk_idle(m == 2'b11 ? "R3 read capture" : "R4 lane gated read");
            e.ack = 1; e.aaddr = a;
            q.push_back(e);
            last_rd = 1;
        end else begin
            logic [15:0] w;
            if (last_rd)
                for (int i = 0; i < TN; i++) q.push_back(mk_idle("R6 turnaround"));
            cur_addr = a;
            for (int i = 0; i < WL; i++) begin
                e = mk_idle(m == 2'b11 ? "R5 write pulse" : "R4 lane write");
                e.sel = 1; e.we_n = 0; e.be_n = ~m; e.dq_oe = 1; e.dout = d;
                q.push_back(e);
            end
            e = mk_idle("R9 write hold");
            e.sel = 1; e.be_n = ~m; e.dq_oe = 1; e.dout = d;
            q.push_back(e);
            e = mk_idle("R5 write ack");
            e.ack = 1; e.aaddr = a;
            q.push_back(e);
            w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
            last_rd = 0;
        end
        foreach (q[i]) begin
            step(q[i]);
            if (q[i].ack) host_req = 0;
        end
        // One quiet cycle: no second acknowledge, address held.
        step(mk_idle("R8 single ack"));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 3; i++) step(mk_idle("R1 reset idle"));

        op(1, 18'h00010, 16'hA1B2, 2'b11);
        op(0, 18'h00010, 16'h0000, 2'b11);
        op(0, 18'h00010, 16'h0000, 2'b01);
        op(1, 18'h00010, 16'hC3D4, 2'b10);   // turnaround after read
        op(0, 18'h00010, 16'h0000, 2'b11);
        op(1, 18'h00020, 16'h1111, 2'b00);   // empty mask write
        op(0, 18'h00020, 16'h0000, 2'b00);   // empty mask read
        op(1, 18'h00020, 16'h2222, 2'b01);   // turnaround survives empty mask
        op(1, 18'h00021, 16'h3333, 2'b11);   // write after write
        op(0, 18'h00020, 16'h0000, 2'b10);
        op(1, 18'h3FFFF, 16'hFEED, 2'b11);
        op(0, 18'h3FFFF, 16'h0000, 2'b11);
        op(0, 18'h00000, 16'h0000, 2'b11);
        for (int i = 0; i < 60; i++) begin
            logic [17:0] a;
            a = ($urandom_range(0, 3) == 0) ? 18'h3FFF0 + 18'($urandom_range(0, 15))
                                            : 18'($urandom_range(0, 7));
            op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 2) == 0) step(mk_idle("R1 idle hold"));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule